// File: doc/BRIEF.md
# Buffered PWM Channel with Pause, Resume and Restart

This block is a single pulse-width modulation channel with an N-bit counter (8 bits by default). Software writes a duty value and a period value into holding buffers. The working copies take those values only at a period boundary or when software writes the counter, so a waveform is never changed halfway through a cycle by an ordinary update. The counter moves only on clock cycles where the external prescaler strobe `tick` is high. Its value can be observed on `cnt_o` at any time with no side effect.

Two waveform shapes are available:
- **Left-aligned:** the counter climbs from 0 to period minus 1 and then wraps.
- **Center-aligned:** the counter climbs to the period value and then descends back to zero.

In both shapes, each period starts with the output at its active level, and a match with the duty value flips the output. The active level is selected by `pol`.

Dropping the enable freezes the counter, and raising it again resumes from the frozen count. A counter write restarts the waveform immediately from a clean state. While the channel is disabled, a zero held in the period buffer clears the counter on the next tick.

Top module: `pwm_chan`

## Requirements
- R1: After reset, `cnt_o` is 0, all buffered and working duty and period values are 0, and `pwm_o` equals `~pol` (inactive).
- R2: A write on `wr_duty` or `wr_period` changes only the buffer; the working duty and period take the buffered values only on a period reload or a counter write. A reload in the same cycle as a buffer write uses the old buffer contents.
- R3: A cycle with `wr_cnt` high makes `cnt_o` 0 after that edge, whatever the values of `en` and `tick`. It also sets the direction to up, copies both buffers into the working registers, and makes the output active, unless the new duty is 0. It has priority over a tick in the same cycle.
- R4: Apart from a counter write, `cnt_o` changes only after an edge where `tick` is 1.
- R5: With `en` low and a nonzero period buffer, `cnt_o` and `pwm_o` hold. After `en` returns high, counting continues from the held value.
- R6: With `en` low and the period buffer equal to 0, a tick clears the counter to 0 and sets the direction to up. With no tick, the counter holds.
- R7: With `center` = 0, each enabled tick advances the counter by 1. A tick at count P-1 (P being the working period) returns the counter to 0 and reloads the working registers.
- R8: With `center` = 1, the counter runs 0, 1, …, P, P-1, …, 1 and then back to 0. Arriving at 0 reloads the working registers and turns the direction to up. The count never exceeds the working period.
- R9: The output is active (`pwm_o` = `pol`) exactly when the working duty D is nonzero and either D ≥ P or the count is below D. Otherwise `pwm_o` = `~pol`. This means D = 0 is always inactive and D ≥ P is always active.
- R10: With `en` high and a working period of 0, every tick keeps the counter at 0 and reloads the working registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count strobe from the external prescaler |
| en | input | 1 | Channel enable; low freezes the counter |
| center | input | 1 | Shape select: 0 = left-aligned, 1 = center-aligned |
| pol | input | 1 | Active output level |
| wr_duty | input | 1 | Write `wr_data` into the duty buffer |
| wr_period | input | 1 | Write `wr_data` into the period buffer |
| wr_cnt | input | 1 | Counter write: restart the waveform |
| wr_data | input | W | Data for the register writes |
| cnt_o | output | W | Current counter value |
| pwm_o | output | 1 | PWM output |

## Verification
The bench builds the block with the default width of 8. This keeps the all-ones period of 255 within reach: a full center-aligned cycle of 510 ticks, including the turn at the top, fits easily in the run. Short periods of 4 to 6 exercise the wrap, the turn at the top, and duty matches in both directions. They also cover duty values of 0 and duty values above the period, strobes arriving every third cycle, pauses, and counter writes with and without a coincident tick. A zero-period case runs both with the channel disabled and with it enabled.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

    typedef enum logic {
        DIR_UP = 1'b0,
        DIR_DN = 1'b1
    } dir_e;

    // Events produced by the counter for the shadow and level stages
    typedef struct packed {
        logic load;      // copy buffers into working registers
        logic clr_zero;  // disabled-channel clear on zero period
        logic up_step;   // counter incremented this tick
        logic dn_step;   // counter decremented this tick
    } cnt_evt_t;

endpackage

// File: rtl/pwm_shadow.sv
module pwm_shadow #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_duty,
    input  logic         wr_period,
    input  logic [W-1:0] wr_data,
    input  logic         load,
    output logic [W-1:0] duty_buf,
    output logic [W-1:0] per_buf,
    output logic [W-1:0] duty_act,
    output logic [W-1:0] per_act
);
    typedef struct packed {
        logic [W-1:0] duty_buf;
        logic [W-1:0] per_buf;
        logic [W-1:0] duty_act;
        logic [W-1:0] per_act;
    } shadow_t;

    shadow_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        // Reload takes the buffer contents present before this edge
        if (load) begin
            sh_d.duty_act = sh_q.duty_buf;
            sh_d.per_act  = sh_q.per_buf;
        end
        if (wr_duty) begin
            sh_d.duty_buf = wr_data;
        end
        if (wr_period) begin
            sh_d.per_buf = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign duty_buf = sh_q.duty_buf;
    assign per_buf  = sh_q.per_buf;
    assign duty_act = sh_q.duty_act;
    assign per_act  = sh_q.per_act;

endmodule

// File: rtl/pwm_count.sv
module pwm_count
    import pwm_chan_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         en,
    input  logic         center,
    input  logic         wr_cnt,
    input  logic         per_buf_zero,
    input  logic [W-1:0] per_act,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_next,
    output cnt_evt_t     evt
);
    localparam logic [W-1:0] ONE   = W'(1);
    localparam logic [W:0]   ONE_X = (W+1)'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
        dir_e         dir;
    } cstate_t;

    cstate_t  st_d, st_q;
    logic [W:0]   cnt_inc;
    logic [W-1:0] cnt_dec;
    logic         left_wrap;
    logic         at_top;

    always_comb begin
        cnt_inc   = {1'b0, st_q.cnt} + ONE_X;
        cnt_dec   = st_q.cnt - ONE;
        left_wrap = cnt_inc >= {1'b0, per_act};
        at_top    = st_q.cnt >= per_act;

        st_d = st_q;
        evt  = '0;

        if (wr_cnt) begin
            // Restart: clear, count up, reload at once
            st_d.cnt = '0;
            st_d.dir = DIR_UP;
            evt.load = 1'b1;
        end else if (tick) begin
            if (en) begin
                if (per_act == '0) begin
                    st_d.cnt = '0;
                    st_d.dir = DIR_UP;
                    evt.load = 1'b1;
                end else if (!center) begin
                    st_d.dir = DIR_UP;
                    if (left_wrap) begin
                        st_d.cnt = '0;
                        evt.load = 1'b1;
                    end else begin
                        st_d.cnt    = cnt_inc[W-1:0];
                        evt.up_step = 1'b1;
                    end
                end else begin
                    if (st_q.dir == DIR_UP && !at_top) begin
                        st_d.cnt    = cnt_inc[W-1:0];
                        evt.up_step = 1'b1;
                    end else if (st_q.cnt == '0) begin
                        // Guard: already at bottom while descending
                        st_d.dir = DIR_UP;
                        evt.load = 1'b1;
                    end else begin
                        st_d.cnt    = cnt_dec;
                        st_d.dir    = DIR_DN;
                        evt.dn_step = 1'b1;
                        if (cnt_dec == '0) begin
                            st_d.dir = DIR_UP;
                            evt.load = 1'b1;
                        end
                    end
                end
            end else if (per_buf_zero) begin
                st_d.cnt     = '0;
                st_d.dir     = DIR_UP;
                evt.clr_zero = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, dir: DIR_UP};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q    = st_q.cnt;
    assign cnt_next = st_d.cnt;

endmodule

// File: rtl/pwm_level.sv
module pwm_level
    import pwm_chan_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  cnt_evt_t     evt,
    input  logic [W-1:0] cnt_q,
    input  logic [W-1:0] cnt_next,
    input  logic [W-1:0] duty_act,
    input  logic [W-1:0] per_act,
    input  logic [W-1:0] duty_buf,
    input  logic         pol,
    output logic         pwm_o
);
    logic act_d, act_q;
    logic duty_lt_per;

    always_comb begin
        duty_lt_per = duty_act < per_act;
        act_d       = act_q;
        if (evt.load) begin
            // New period starts active unless the incoming duty is zero
            act_d = (duty_buf != '0);
        end else if (evt.clr_zero) begin
            act_d = (duty_act != '0);
        end else if (evt.up_step && duty_lt_per && cnt_next == duty_act) begin
            act_d = 1'b0;
        end else if (evt.dn_step && duty_lt_per && duty_act != '0
                     && cnt_q == duty_act) begin
            act_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= 1'b0;
        end else begin
            act_q <= act_d;
        end
    end

    assign pwm_o = act_q ? pol : ~pol;

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_chan_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         en,
    input  logic         center,
    input  logic         pol,
    input  logic         wr_duty,
    input  logic         wr_period,
    input  logic         wr_cnt,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cnt_o,
    output logic         pwm_o
);
    logic [W-1:0] duty_buf, per_buf, duty_act, per_act;
    logic [W-1:0] cnt_q, cnt_next;
    cnt_evt_t     evt;

    pwm_shadow #(.W(W)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_duty   (wr_duty),
        .wr_period (wr_period),
        .wr_data   (wr_data),
        .load      (evt.load),
        .duty_buf  (duty_buf),
        .per_buf   (per_buf),
        .duty_act  (duty_act),
        .per_act   (per_act)
    );

    pwm_count #(.W(W)) u_count (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .en           (en),
        .center       (center),
        .wr_cnt       (wr_cnt),
        .per_buf_zero (per_buf == '0),
        .per_act      (per_act),
        .cnt_q        (cnt_q),
        .cnt_next     (cnt_next),
        .evt          (evt)
    );

    pwm_level #(.W(W)) u_level (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .cnt_q    (cnt_q),
        .cnt_next (cnt_next),
        .duty_act (duty_act),
        .per_act  (per_act),
        .duty_buf (duty_buf),
        .pol      (pol),
        .pwm_o    (pwm_o)
    );

    assign cnt_o = cnt_q;

endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic         en,
    input logic         center,
    input logic         pol,
    input logic         wr_cnt,
    input logic [W-1:0] cnt_o,
    input logic         pwm_o,
    input logic [W-1:0] duty_act,
    input logic [W-1:0] per_act,
    input logic [W-1:0] per_buf
);
    // R4
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_cnt) |=> $stable(cnt_o));

    // R3
    cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (cnt_o == '0));

    // R5
    cnt_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !wr_cnt && per_buf != '0) |=> $stable(cnt_o));

    // R7
    left_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && en && !center && !wr_cnt)
        |=> (cnt_o == '0 || cnt_o == W'($past(cnt_o) + 1'b1)));

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o <= per_act);

    // R9
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_act == '0) |-> (pwm_o == ~pol));

    // R9
    full_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_act != '0 && duty_act >= per_act) |-> (pwm_o == pol));

endmodule

bind pwm_chan pwm_chan_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .en       (en),
    .center   (center),
    .pol      (pol),
    .wr_cnt   (wr_cnt),
    .cnt_o    (cnt_o),
    .pwm_o    (pwm_o),
    .duty_act (duty_act),
    .per_act  (per_act),
    .per_buf  (per_buf)
);

// File: tb/pwm_chan_test.sv
module pwm_chan_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         en = 1'b0;
    logic         center = 1'b0;
    logic         pol = 1'b1;
    logic         wr_duty = 1'b0;
    logic         wr_period = 1'b0;
    logic         wr_cnt = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] cnt_o;
    logic         pwm_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_chan #(.W(W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .en        (en),
        .center    (center),
        .pol       (pol),
        .wr_duty   (wr_duty),
        .wr_period (wr_period),
        .wr_cnt    (wr_cnt),
        .wr_data   (wr_data),
        .cnt_o     (cnt_o),
        .pwm_o     (pwm_o)
    );

    typedef struct {
        logic [W-1:0] cnt;
        logic         pwm;
        string        tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t cur;
    int   n_cmp = 0;
    int   n_bad = 0;

    // Reference state built from the requirements
    logic [W-1:0] m_cnt = '0, m_dbuf = '0, m_pbuf = '0, m_dact = '0, m_pact = '0;
    logic         m_down = 1'b0;

    function automatic logic m_level();
        logic active;
        active = (m_dact != '0) && ((m_dact >= m_pact) || (m_cnt < m_dact));
        return active ? pol : ~pol;
    endfunction

    task automatic model_step();
        logic [W-1:0] nd, np;
        logic rl;
        nd = m_dbuf;
        np = m_pbuf;
        rl = 1'b0;
        if (wr_cnt) begin
            m_cnt = '0; m_down = 1'b0; rl = 1'b1;
        end else if (tick && en) begin
            if (m_pact == '0) begin
                m_cnt = '0; m_down = 1'b0; rl = 1'b1;
            end else if (!center) begin
                m_down = 1'b0;
                if (int'(m_cnt) + 1 >= int'(m_pact)) begin
                    m_cnt = '0; rl = 1'b1;
                end else begin
                    m_cnt = m_cnt + 1'b1;
                end
            end else begin
                if (!m_down && m_cnt < m_pact) begin
                    m_cnt = m_cnt + 1'b1;
                end else begin
                    m_cnt  = m_cnt - 1'b1;
                    m_down = 1'b1;
                    if (m_cnt == '0) begin
                        m_down = 1'b0; rl = 1'b1;
                    end
                end
            end
        end else if (tick && !en && m_pbuf == '0) begin
            m_cnt = '0; m_down = 1'b0;
        end
        if (rl) begin
            m_dact = nd; m_pact = np;
        end
        if (wr_duty)   m_dbuf = wr_data;
        if (wr_period) m_pbuf = wr_data;
    endtask

    // Driver: called at a falling edge, applies one cycle of stimulus
    task automatic cyc(input logic t, input string tag);
        tick = t;
        model_step();
        exp_q.push_back('{cnt: m_cnt, pwm: m_level(), tag: tag});
        @(negedge clk);
        tick = 1'b0; wr_cnt = 1'b0; wr_duty = 1'b0; wr_period = 1'b0;
    endtask

    task automatic wduty(input logic [W-1:0] v, input string tag);
        wr_duty = 1'b1; wr_data = v; cyc(1'b0, tag);
    endtask

    task automatic wper(input logic [W-1:0] v, input string tag);
        wr_period = 1'b1; wr_data = v; cyc(1'b0, tag);
    endtask

    task automatic wcnt(input logic t, input string tag);
        wr_cnt = 1'b1; wr_data = 8'hA5; cyc(t, tag);
    endtask

    task automatic run(input int n, input int every, input string tag);
        for (int i = 0; i < n; i++) begin
            cyc((i % every) == 0, tag);
        end
    endtask

    // Monitor: compares each result one step after its clock edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() != 0) begin
            cur = exp_q.pop_front();
            n_cmp++;
            if (cnt_o !== cur.cnt || pwm_o !== cur.pwm) begin
                n_bad++;
                $display("FAIL %s: cnt=%0d pwm=%b expected cnt=%0d pwm=%b",
                         cur.tag, cnt_o, pwm_o, cur.cnt, cur.pwm);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        n_cmp++;
        if (cnt_o !== '0 || pwm_o !== ~pol) begin
            n_bad++;
            $display("FAIL R1: cnt=%0d pwm=%b expected cnt=0 pwm=%b", cnt_o, pwm_o, ~pol);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2: buffer writes alone leave the output inactive
        wduty(8'd2, "R2");
        wper(8'd5, "R2");
        run(3, 1, "R2");
        en = 1'b1;
        wcnt(1'b0, "R3");
        run(23, 1, "R7");
        // R2: mid-period duty change waits for the reload
        wduty(8'd4, "R2");
        run(12, 1, "R2");
        // R4: sparse ticks
        run(30, 3, "R4");
        // R5: pause and resume
        en = 1'b0;
        run(10, 1, "R5");
        en = 1'b1;
        run(10, 1, "R5");
        // R3: restart with and without a coincident tick
        run(2, 1, "R3");
        wcnt(1'b1, "R3");
        run(3, 1, "R3");
        en = 1'b0;
        wcnt(1'b0, "R3");
        en = 1'b1;
        run(2, 1, "R3");
        // R8: center-aligned, inverted polarity
        center = 1'b1; pol = 1'b0;
        wduty(8'd1, "R8");
        wper(8'd4, "R8");
        wcnt(1'b0, "R8");
        run(30, 1, "R8");
        wduty(8'd3, "R9");
        run(20, 1, "R9");
        // R9: duty above period, then duty zero
        wduty(8'd6, "R9");
        wcnt(1'b0, "R9");
        run(20, 1, "R9");
        wduty(8'd0, "R9");
        wcnt(1'b0, "R9");
        run(12, 1, "R9");
        // R6: zero period while disabled
        center = 1'b0; pol = 1'b1;
        wduty(8'd2, "R7");
        wper(8'd6, "R7");
        wcnt(1'b0, "R7");
        run(4, 1, "R7");
        en = 1'b0;
        wper(8'd0, "R6");
        run(3, 2, "R6");
        run(2, 1, "R6");
        // R10: enabled with zero working period after reload
        en = 1'b1;
        run(5, 1, "R7");
        run(12, 1, "R10");
        // R8: full-range center-aligned period
        center = 1'b1;
        wduty(8'd128, "R8");
        wper(8'd255, "R8");
        wcnt(1'b0, "R8");
        run(520, 1, "R8");

        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule